// File: doc/BRIEF.md
# Hunt-Mode Synchronous Serial Receiver

This block turns a serial bit stream into parallel characters for a processor. Bits arrive on a single data input and are qualified by a one-cycle receive timing strobe from outside the block. After reset, and whenever reception is re-enabled, the receiver does not assemble data. It first hunts for a framing pattern. In bit-oriented mode this pattern is the fixed flag 8'b01111110. In character-oriented mode it is a sync character taken from an 8-bit input.

Once the pattern has matched, the receiver enters the in-sync state. From then on it shifts one bit per strobe into an assembly register, least significant bit first, until a character of the programmed length is complete. The finished character is copied into a holding buffer and a data-ready flag is raised. Because of this double buffering, the next character can be assembled while the processor has not yet fetched the previous one. A processor read of the buffer clears data-ready. A completion that lands on an unread buffer overwrites it and sets a sticky overrun flag, which a status read clears.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, data_ready, overrun and in_sync are 0 and rd_data is 8'h00.
- R2: With bit_mode=1, in_sync rises in the cycle after the strobe that completes the bits 0,1,1,1,1,1,1,0 in arrival order. Until then no character is delivered.
- R3: With bit_mode=0, the pattern is the low N bits of sync_char, received least significant bit first. Here N is the character length. The sync character itself is never delivered as data.
- R4: While hunting, a match is accepted only once at least N bits (8 in bit mode) have been received since the hunt began. A sync_char of zero therefore needs N zero bits.
- R5: In sync, exactly one bit is taken per cycle with rx_strobe=1, and rx_bit is ignored otherwise. char_len selects N: 00=5, 01=6, 10=7, 11=8 bits. The first bit received lands in bit 0 of rd_data, and the bits above N-1 read as 0.
- R6: data_ready is 1 in the cycle after the strobe that completes a character, and rd_data then holds that character.
- R7: The next character is assembled while the buffer is full. A one-cycle rd_data_en pulse clears data_ready in the following cycle and leaves rd_data unchanged.
- R8: A completion while data_ready=1 and rd_data_en=0 overwrites the buffer and sets overrun, which stays set until an rd_stat_en pulse clears it. A completion in the same cycle as rd_data_en keeps data_ready at 1 and sets no overrun.
- R9: rx_en=0 makes in_sync 0 in the next cycle and discards any partial character, while the buffer, data_ready and overrun are kept. After re-enable, no data is delivered until a new pattern match.
- R10: Strobes while rx_en=0 have no effect on data_ready or rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low forces the hunt state |
| bit_mode | input | 1 | 1 = hunt for flag, 0 = hunt for sync character |
| sync_char | input | 8 | Sync character for character-oriented mode |
| char_len | input | 2 | Character length code (5 + value bits) |
| rx_strobe | input | 1 | Receive timing strobe, one bit per pulse |
| rx_bit | input | 1 | Serial receive data |
| rd_data_en | input | 1 | Processor read of the receive buffer |
| rd_stat_en | input | 1 | Processor read of status, clears overrun |
| rd_data | output | 8 | Buffered character, right-justified |
| data_ready | output | 1 | Buffer holds an unread character |
| overrun | output | 1 | Sticky overrun flag |
| in_sync | output | 1 | Pattern matched, assembling characters |

## Verification
The assertions check the following on every cycle:
- disabling drops in_sync in the next cycle;
- the assembler never completes a character while hunting;
- every buffer load raises data-ready, and the buffer holds its value unless a load occurs;
- a load onto an unread buffer sets overrun;
- the bit counter stays in range.

The bench scenarios show the behaviour that depends on the bit order and content of the stream:
- that each pattern matches on exactly its final bit and not before;
- the minimum-fill rule for an all-zero sync;
- right-justified characters of every length;
- the outcome when a read and a completion coincide;
- that partial characters are discarded after a disable.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    localparam int CHAR_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [CHAR_W-1:0] FLAG_PAT = 8'h7E;

    typedef enum logic {ST_HUNT, ST_ASM} rx_state_e;

    // number of bits in a character for a length code
    function automatic logic [CNT_W-1:0] len_bits(input logic [1:0] code);
        return CNT_W'(5) + {2'b00, code};
    endfunction

    // right-justify the newest N bits held at the top of a window
    function automatic logic [CHAR_W-1:0] rjust(input logic [CHAR_W-1:0] v,
                                                input logic [1:0] code);
        logic [2:0] sh;
        sh = 3'd3 - {1'b0, code};
        return v >> sh;
    endfunction

    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
        logic [2:0] sh;
        sh = 3'd3 - {1'b0, code};
        return {CHAR_W{1'b1}} >> sh;
    endfunction
endpackage

// File: rtl/sync_hunt_detect.sv
module sync_hunt_detect
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              strobe,
    input  logic              bit_i,
    input  logic              bit_mode,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic [1:0]        char_len,
    output logic              match
);
    logic [CHAR_W-1:0] win_q, win_nxt, got, want;
    logic [CNT_W-1:0]  fill_q, need;

    always_comb begin
        win_nxt = {bit_i, win_q[CHAR_W-1:1]};
        want    = bit_mode ? FLAG_PAT : (sync_char & len_mask(char_len));
        got     = bit_mode ? win_nxt : rjust(win_nxt, char_len);
        need    = bit_mode ? CNT_W'(CHAR_W) : len_bits(char_len);
        match   = strobe && ((fill_q + CNT_W'(1)) >= need) && (got == want);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (strobe) begin
            win_q <= win_nxt;
            if (fill_q < CNT_W'(CHAR_W))
                fill_q <= fill_q + CNT_W'(1);
        end
    end

    // R4: fill count never exceeds the window size
    p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CNT_W'(CHAR_W));
endmodule

// File: rtl/sync_char_asm.sv
module sync_char_asm
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              strobe,
    input  logic              bit_i,
    input  logic [1:0]        char_len,
    output logic              done,
    output logic [CHAR_W-1:0] char_out
);
    logic [CHAR_W-1:0] sh_q, sh_nxt;
    logic [CNT_W-1:0]  cnt_q;

    always_comb begin
        sh_nxt   = {bit_i, sh_q[CHAR_W-1:1]};
        done     = strobe && ((cnt_q + CNT_W'(1)) == len_bits(char_len));
        char_out = rjust(sh_nxt, char_len);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (strobe) begin
            sh_q  <= sh_nxt;
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R5: bit counter stays below the longest character
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(CHAR_W));
endmodule

// File: rtl/sync_rx_buffer.sv
module sync_rx_buffer
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_val,
    input  logic              rd_data_en,
    input  logic              rd_stat_en,
    output logic [CHAR_W-1:0] buf_q,
    output logic              ready_q,
    output logic              ovr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (load)
                buf_q <= load_val;
            if (load)
                ready_q <= 1'b1;
            else if (rd_data_en)
                ready_q <= 1'b0;
            if (load && ready_q && !rd_data_en)
                ovr_q <= 1'b1;
            else if (rd_stat_en)
                ovr_q <= 1'b0;
        end
    end

    p_ready_set_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> ready_q);
    p_buf_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(buf_q));
    p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
        (load && ready_q && !rd_data_en) |=> ovr_q);
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              bit_mode,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic [1:0]        char_len,
    input  logic              rx_strobe,
    input  logic              rx_bit,
    input  logic              rd_data_en,
    input  logic              rd_stat_en,
    output logic [CHAR_W-1:0] rd_data,
    output logic              data_ready,
    output logic              overrun,
    output logic              in_sync
);
    rx_state_e         state_q;
    logic              hunting, assembling, match, asm_done;
    logic [CHAR_W-1:0] asm_char;

    assign hunting    = rx_en && (state_q == ST_HUNT);
    assign assembling = rx_en && (state_q == ST_ASM);
    assign in_sync    = (state_q == ST_ASM);

    always_ff @(posedge clk) begin
        if (rst || !rx_en)
            state_q <= ST_HUNT;
        else if (hunting && match)
            state_q <= ST_ASM;
    end

    sync_hunt_detect u_hunt (
        .clk       (clk),
        .rst       (rst),
        .clr       (!hunting),
        .strobe    (rx_strobe && hunting),
        .bit_i     (rx_bit),
        .bit_mode  (bit_mode),
        .sync_char (sync_char),
        .char_len  (char_len),
        .match     (match)
    );

    sync_char_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .clr      (!assembling),
        .strobe   (rx_strobe && assembling),
        .bit_i    (rx_bit),
        .char_len (char_len),
        .done     (asm_done),
        .char_out (asm_char)
    );

    sync_rx_buffer u_buf (
        .clk        (clk),
        .rst        (rst),
        .load       (asm_done),
        .load_val   (asm_char),
        .rd_data_en (rd_data_en),
        .rd_stat_en (rd_stat_en),
        .buf_q      (rd_data),
        .ready_q    (data_ready),
        .ovr_q      (overrun)
    );

    p_disable_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !in_sync);
    p_no_load_hunt_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT) |-> !asm_done);
endmodule

// File: tb/sync_hunt_rx_tb.sv
module sync_hunt_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0, bit_mode = 1'b0, rx_strobe = 1'b0, rx_bit = 1'b0;
    logic       rd_data_en = 1'b0, rd_stat_en = 1'b0;
    logic [7:0] sync_char = 8'h00;
    logic [1:0] char_len = 2'b11;
    logic [7:0] rd_data;
    logic       data_ready, overrun, in_sync;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    sync_hunt_rx dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .bit_mode(bit_mode),
        .sync_char(sync_char), .char_len(char_len), .rx_strobe(rx_strobe),
        .rx_bit(rx_bit), .rd_data_en(rd_data_en), .rd_stat_en(rd_stat_en),
        .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
        .in_sync(in_sync)
    );

    // {bit_mode, char_len, sync_char, data}
    localparam logic [18:0] VEC [0:5] = '{
        {1'b1, 2'b11, 8'h00, 8'hA5},
        {1'b1, 2'b00, 8'h00, 8'h13},
        {1'b0, 2'b11, 8'h16, 8'h3C},
        {1'b0, 2'b10, 8'h2D, 8'h55},
        {1'b0, 2'b01, 8'h0A, 8'h2B},
        {1'b0, 2'b00, 8'h09, 8'h1E}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_strobe = 1'b1; rx_bit = b;
        @(negedge clk); rx_strobe = 1'b0; rx_bit = ~b;  // toggle without strobe
    endtask

    task automatic send_bits(input logic [7:0] v, input int from, input int upto);
        for (int k = from; k < upto; k++) send_bit(v[k]);
    endtask

    task automatic rd_buf();
        @(negedge clk); rd_data_en = 1'b1;
        @(negedge clk); rd_data_en = 1'b0;
    endtask

    task automatic rd_stat();
        @(negedge clk); rd_stat_en = 1'b1;
        @(negedge clk); rd_stat_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready", data_ready, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 in_sync", in_sync, 0);
        chk("R1 rd_data", rd_data, 0);

        for (int i = 0; i < 6; i++) begin
            logic md; logic [1:0] ln; logic [7:0] sy, dt, pat, msk;
            int np, nd;
            {md, ln, sy, dt} = VEC[i];
            nd  = 5 + ln;
            np  = md ? 8 : nd;
            pat = md ? 8'h7E : sy;
            msk = 8'hFF >> (8 - nd);
            @(negedge clk); rx_en = 1'b0; bit_mode = md; char_len = ln; sync_char = sy;
            rd_buf();
            @(negedge clk); rx_en = 1'b1;
            send_bit(1'b0); send_bit(1'b0);
            send_bits(pat, 0, np - 1);
            chk(md ? "R2 before flag end" : "R3 before sync end", in_sync, 0);
            send_bits(pat, np - 1, np);
            chk(md ? "R2 flag match" : "R3 sync match", in_sync, 1);
            chk("R3 pattern not delivered", data_ready, 0);
            send_bits(dt, 0, nd);
            chk("R6 ready after char", data_ready, 1);
            chk("R5 char value", rd_data, {24'h0, dt & msk});
        end

        // R4: zero sync needs N bits of fill
        @(negedge clk); rx_en = 1'b0; bit_mode = 1'b0; char_len = 2'b11; sync_char = 8'h00;
        rd_buf();
        @(negedge clk); rx_en = 1'b1;
        send_bits(8'h00, 0, 7);
        chk("R4 no early match", in_sync, 0);
        send_bit(1'b0);
        chk("R4 match at N bits", in_sync, 1);

        // R7: double buffering and read
        send_bits(8'h5A, 0, 8);
        chk("R7 first char ready", data_ready, 1);
        send_bits(8'hC3, 0, 4);
        rd_buf();
        chk("R7 read clears ready", data_ready, 0);
        chk("R7 read keeps data", rd_data, 8'h5A);
        send_bits(8'hC3, 4, 8);
        chk("R7 second char ready", data_ready, 1);
        chk("R7 second char value", rd_data, 8'hC3);
        chk("R7 no overrun", overrun, 0);

        // R8: overrun and clearing
        send_bits(8'h81, 0, 8);
        chk("R8 overrun set", overrun, 1);
        chk("R8 overwritten", rd_data, 8'h81);
        rd_stat();
        chk("R8 status read clears", overrun, 0);
        chk("R8 ready kept", data_ready, 1);
        send_bits(8'h66, 0, 7);
        @(negedge clk); rx_strobe = 1'b1; rx_bit = 1'b0; rd_data_en = 1'b1;
        @(negedge clk); rx_strobe = 1'b0; rd_data_en = 1'b0;
        chk("R8 same-cycle read ready", data_ready, 1);
        chk("R8 same-cycle read no overrun", overrun, 0);
        chk("R8 same-cycle value", rd_data, 8'h66);

        // R9/R10: disable mid-character
        send_bits(8'hFF, 0, 3);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk);
        chk("R9 in_sync drops", in_sync, 0);
        chk("R9 buffer kept", rd_data, 8'h66);
        chk("R9 ready kept", data_ready, 1);
        rd_buf();
        send_bits(8'hF0, 0, 8);
        chk("R10 strobes ignored ready", data_ready, 0);
        chk("R10 strobes ignored data", rd_data, 8'h66);
        @(negedge clk); rx_en = 1'b1;
        send_bits(8'hA5, 0, 8);
        send_bits(8'h5B, 0, 8);
        chk("R9 re-hunt no sync", in_sync, 0);
        chk("R9 re-hunt no data", data_ready, 0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule